// File: doc/BRIEF.md
# ADC Conversion Result Store

This block receives finished conversions from an analog-to-digital converter sequencer and keeps them until they are read. Each incoming conversion carries a 10-bit value, a channel number (0 to 15) and a group tag. Group code 0 is the event group, 1 is group 1 and 2 is group 2. Code 3 is not a valid group. Each group also has its own 16-bit channel mask, and a conversion is kept only if the mask of its group has that channel's bit set.

A single mode input picks where kept results go. With the mode input low, results are stored by channel: result register N holds the latest value seen on channel N. With the mode input high, results are stored by group: each group has its own 16-entry queue that keeps values in the order they arrived, whatever their channel. Each queue shows its oldest entry on its read port, and a one-cycle pop strobe removes that entry. Each queue drives a request line that stays high while the queue holds data, so a DMA engine or an interrupt controller can use it to pace its reads.

Each queue tracks how full it is with a three-state machine: FILL_EMPTY, FILL_PART and FILL_FULL. The transitions are:
- FILL_EMPTY to FILL_PART on an accepted push.
- FILL_PART to FILL_FULL on a push without a pop while holding 15 entries.
- FILL_PART to FILL_EMPTY on a pop without a push while holding one entry.
- FILL_FULL to FILL_PART on a pop.
- Every other case stays in place.

Each group also has two sticky flags. The data flag is set whenever a result for that group is kept, in either mode. The overrun flag is set whenever a queue write is dropped. Each is cleared by its own clear strobe.

Top module: `adcbuf_top`

## Requirements
- R1: After reset, every channel result register reads 0, every queue is empty (`grp_empty` = 3'b111, `grp_full` = 0), and `grp_req`, `grp_flag` and `grp_ovr` are 0. Each `grp_rdata` slice reads 0.
- R2: With `mode_buf` = 0, a kept conversion on channel N overwrites result register N. The new value appears on `ch_data` (with `ch_sel` = N) in the cycle after the conversion. The group queues are not touched.
- R3: A conversion is kept only when `conv_grp` is 0, 1 or 2 and bit `conv_ch` of that group's mask (`grp_mask[g*16 +: 16]`) is 1. Any other conversion changes no register, queue or flag.
- R4: With `mode_buf` = 1, a kept conversion is appended to the queue of its group, in arrival order and regardless of channel. The channel result registers are left unchanged.
- R5: Slice `grp_rdata[g*10 +: 10]` shows the oldest entry of queue g. A one-cycle `grp_pop[g]` pulse removes that entry. An empty queue reads 0 with `grp_empty[g]` = 1, and popping it has no effect.
- R6: A queue holds 16 entries, and `grp_full[g]` = 1 when it holds 16. A write to a full queue is dropped, even if a pop happens in the same cycle. The drop sets `grp_ovr[g]`, which stays set until an `ovr_clr[g]` pulse. If a drop and a clear happen together, the set wins.
- R7: `grp_req[g]` is 1 exactly when queue g is not empty.
- R8: `grp_flag[g]` is set in the cycle after any kept conversion of group g, in either mode. It stays set until a `flag_clr[g]` pulse. If a set and a clear happen together, the set wins.
- R9: The three groups are independent. Traffic on one group's queue, flags or strobes never changes another group's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_buf | input | 1 | 0 = store by channel, 1 = queue by group |
| conv_valid | input | 1 | A conversion is presented this cycle |
| conv_ch | input | 4 | Channel of the conversion |
| conv_grp | input | 2 | Group of the conversion (0 event, 1, 2) |
| conv_data | input | 10 | Conversion value |
| grp_mask | input | 48 | Channel masks, group g at [g*16 +: 16] |
| ch_sel | input | 4 | Channel result register to read |
| grp_pop | input | 3 | Pop strobe per group |
| flag_clr | input | 3 | Clear strobe for each data flag |
| ovr_clr | input | 3 | Clear strobe for each overrun flag |
| ch_data | output | 10 | Contents of the selected channel register |
| grp_rdata | output | 30 | Oldest queue entry per group, group g at [g*10 +: 10] |
| grp_empty | output | 3 | Queue empty per group |
| grp_full | output | 3 | Queue full per group |
| grp_req | output | 3 | Data request per group |
| grp_flag | output | 3 | Sticky data flag per group |
| grp_ovr | output | 3 | Sticky overrun flag per group |

## Verification
In channel mode, the bench writes the same channel from two different groups, which shows that the register is indexed by channel and not by group. It then sends a masked channel and the invalid group code 3, which shows that both are discarded. In queue mode, it sends one group results on channels in non-ascending order, which shows that arrival order beats channel order. It also interleaves two groups, which shows that each keeps its own queue and request. Finally, it fills one queue past its depth, with and without a same-cycle pop, to separate dropped writes from stored ones and to test the sticky overrun and its clear.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
    localparam int DEF_NCH   = 16;
    localparam int DEF_RES_W = 10;
    localparam int DEF_NGRP  = 3;
    localparam int DEF_DEPTH = 16;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_e;
endpackage

// File: rtl/adcbuf_chregs.sv
module adcbuf_chregs #(
    parameter int NCH   = adcbuf_pkg::DEF_NCH,
    parameter int RES_W = adcbuf_pkg::DEF_RES_W,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CHW-1:0]   wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CHW-1:0]   rd_ch,
    output logic [RES_W-1:0] rd_data
);
    logic [RES_W-1:0] regs [NCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) regs[i] <= '0;
        end else if (wr) begin
            regs[wr_ch] <= wr_data;
        end
    end

    assign rd_data = regs[rd_ch];
endmodule

// File: rtl/adcbuf_fifo.sv
module adcbuf_fifo
    import adcbuf_pkg::*;
#(
    parameter int RES_W = DEF_RES_W,
    parameter int DEPTH = DEF_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    fill_e            st, st_nx;
    logic [CW-1:0]    cnt;
    logic [AW-1:0]    wp, rp;
    logic [RES_W-1:0] mem [DEPTH];
    logic             do_push, do_pop;

    assign do_push = push && (st != FILL_FULL);
    assign do_pop  = pop  && (st != FILL_EMPTY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= FILL_EMPTY;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            FILL_EMPTY: if (do_push) st_nx = FILL_PART;
            FILL_PART: begin
                if (do_push && !do_pop && cnt == CW'(DEPTH - 1))
                    st_nx = FILL_FULL;
                else if (do_pop && !do_push && cnt == CW'(1))
                    st_nx = FILL_EMPTY;
            end
            FILL_FULL:  if (do_pop) st_nx = FILL_PART;
            default:    st_nx = FILL_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        empty = (st == FILL_EMPTY);
        full  = (st == FILL_FULL);
        head  = empty ? '0 : mem[rp];
        drop  = push && full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            wp  <= '0;
            rp  <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (do_push && !do_pop)      cnt <= cnt + CW'(1);
            else if (do_pop && !do_push) cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/adcbuf_top.sv
module adcbuf_top
    import adcbuf_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int RES_W = DEF_RES_W,
    parameter int NGRP  = DEF_NGRP,
    parameter int DEPTH = DEF_DEPTH,
    localparam int CHW  = $clog2(NCH),
    localparam int GW   = $clog2(NGRP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_buf,
    input  logic                  conv_valid,
    input  logic [CHW-1:0]        conv_ch,
    input  logic [GW-1:0]         conv_grp,
    input  logic [RES_W-1:0]      conv_data,
    input  logic [NGRP*NCH-1:0]   grp_mask,
    input  logic [CHW-1:0]        ch_sel,
    input  logic [NGRP-1:0]       grp_pop,
    input  logic [NGRP-1:0]       flag_clr,
    input  logic [NGRP-1:0]       ovr_clr,
    output logic [RES_W-1:0]      ch_data,
    output logic [NGRP*RES_W-1:0] grp_rdata,
    output logic [NGRP-1:0]       grp_empty,
    output logic [NGRP-1:0]       grp_full,
    output logic [NGRP-1:0]       grp_req,
    output logic [NGRP-1:0]       grp_flag,
    output logic [NGRP-1:0]       grp_ovr
);
    logic [NCH-1:0]  sel_mask;
    logic [NGRP-1:0] grp_hit;
    logic            accept;

    always_comb begin
        sel_mask = '0;
        grp_hit  = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (conv_grp == GW'(g)) begin
                sel_mask   = grp_mask[g*NCH +: NCH];
                grp_hit[g] = 1'b1;
            end
        end
        accept = conv_valid && sel_mask[conv_ch];
    end

    adcbuf_chregs #(.NCH(NCH), .RES_W(RES_W)) u_chregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (accept && !mode_buf),
        .wr_ch   (conv_ch),
        .wr_data (conv_data),
        .rd_ch   (ch_sel),
        .rd_data (ch_data)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic drop;
        logic push;

        assign push = accept && mode_buf && grp_hit[g];

        adcbuf_fifo #(.RES_W(RES_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push),
            .pop   (grp_pop[g]),
            .din   (conv_data),
            .head  (grp_rdata[g*RES_W +: RES_W]),
            .empty (grp_empty[g]),
            .full  (grp_full[g]),
            .drop  (drop)
        );

        assign grp_req[g] = !grp_empty[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_flag[g] <= 1'b0;
                grp_ovr[g]  <= 1'b0;
            end else begin
                if (accept && grp_hit[g]) grp_flag[g] <= 1'b1;
                else if (flag_clr[g])     grp_flag[g] <= 1'b0;
                if (drop)                 grp_ovr[g]  <= 1'b1;
                else if (ovr_clr[g])      grp_ovr[g]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adcbuf_chk.sv
module adcbuf_chk #(
    parameter int NCH   = 16,
    parameter int RES_W = 10,
    parameter int NGRP  = 3,
    localparam int CHW  = $clog2(NCH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mode_buf,
    input logic                  conv_valid,
    input logic [CHW-1:0]        ch_sel,
    input logic [NGRP-1:0]       grp_pop,
    input logic [NGRP-1:0]       flag_clr,
    input logic [NGRP-1:0]       ovr_clr,
    input logic [RES_W-1:0]      ch_data,
    input logic [NGRP*RES_W-1:0] grp_rdata,
    input logic [NGRP-1:0]       grp_empty,
    input logic [NGRP-1:0]       grp_full,
    input logic [NGRP-1:0]       grp_flag,
    input logic [NGRP-1:0]       grp_ovr
);
    // R4
    ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_buf ##1 $stable(ch_sel) |-> $stable(ch_data));

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        // R2
        queue_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_buf && !grp_pop[g] |=> $stable(grp_empty[g]) && $stable(grp_rdata[g*RES_W +: RES_W]));
        // R5
        empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_empty[g] |-> grp_rdata[g*RES_W +: RES_W] == '0);
        // R6
        ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_ovr[g] && !ovr_clr[g] |=> grp_ovr[g]);
        // R6
        ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_ovr[g]) |-> $past(grp_full[g]) && $past(conv_valid) && $past(mode_buf));
        // R8
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_flag[g] && !flag_clr[g] |=> grp_flag[g]);
        // R8
        flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_flag[g]) |-> $past(conv_valid));
    end
endmodule

bind adcbuf_top adcbuf_chk #(.NCH(NCH), .RES_W(RES_W), .NGRP(NGRP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_buf   (mode_buf),
    .conv_valid (conv_valid),
    .ch_sel     (ch_sel),
    .grp_pop    (grp_pop),
    .flag_clr   (flag_clr),
    .ovr_clr    (ovr_clr),
    .ch_data    (ch_data),
    .grp_rdata  (grp_rdata),
    .grp_empty  (grp_empty),
    .grp_full   (grp_full),
    .grp_flag   (grp_flag),
    .grp_ovr    (grp_ovr)
);

// File: tb/sim_adcbuf_top.sv
module sim_adcbuf_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_buf = 1'b0;
    logic        conv_valid = 1'b0;
    logic [3:0]  conv_ch = '0;
    logic [1:0]  conv_grp = '0;
    logic [9:0]  conv_data = '0;
    logic [47:0] grp_mask = '1;
    logic [3:0]  ch_sel = '0;
    logic [2:0]  grp_pop = '0;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  ovr_clr = '0;
    logic [9:0]  ch_data;
    logic [29:0] grp_rdata;
    logic [2:0]  grp_empty, grp_full, grp_req, grp_flag, grp_ovr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .conv_valid(conv_valid),
        .conv_ch(conv_ch), .conv_grp(conv_grp), .conv_data(conv_data),
        .grp_mask(grp_mask), .ch_sel(ch_sel), .grp_pop(grp_pop),
        .flag_clr(flag_clr), .ovr_clr(ovr_clr), .ch_data(ch_data),
        .grp_rdata(grp_rdata), .grp_empty(grp_empty), .grp_full(grp_full),
        .grp_req(grp_req), .grp_flag(grp_flag), .grp_ovr(grp_ovr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic conv(input int ch, input int grp, input int dat, input logic [2:0] popm);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_ch    = 4'(ch);
        conv_grp   = 2'(grp);
        conv_data  = 10'(dat);
        grp_pop    = popm;
        @(negedge clk);
        conv_valid = 1'b0;
        grp_pop    = '0;
    endtask

    task automatic pop(input int g);
        @(negedge clk);
        grp_pop[g] = 1'b1;
        @(negedge clk);
        grp_pop = '0;
    endtask

    task automatic pulse_clr(input logic [2:0] fm, input logic [2:0] om);
        @(negedge clk);
        flag_clr = fm;
        ovr_clr  = om;
        @(negedge clk);
        flag_clr = '0;
        ovr_clr  = '0;
    endtask

    function automatic int head(input int g);
        return int'(grp_rdata[g*10 +: 10]);
    endfunction

    task automatic rd_ch(input int ch, output int v);
        ch_sel = 4'(ch);
        #1;
        v = int'(ch_data);
    endtask

    task automatic t_reset();
        int v;
        for (int c = 0; c < 16; c++) begin
            rd_ch(c, v);
            chk("R1 chreg zero", v, 0);
        end
        chk("R1 empty", int'(grp_empty), 7);
        chk("R1 full", int'(grp_full), 0);
        chk("R1 req", int'(grp_req), 0);
        chk("R1 flag", int'(grp_flag), 0);
        chk("R1 ovr", int'(grp_ovr), 0);
        chk("R1 rdata", int'(grp_rdata), 0);
    endtask

    task automatic t_compat();
        int v;
        mode_buf = 1'b0;
        conv(5, 1, 'h155, 3'b000);
        rd_ch(5, v);
        chk("R2 write ch5", v, 'h155);
        chk("R8 flag g1 set", int'(grp_flag), 3'b010);
        chk("R2 queues untouched", int'(grp_empty), 7);
        conv(5, 0, 'h2AA, 3'b000);
        rd_ch(5, v);
        chk("R2 overwrite ch5 from other group", v, 'h2AA);
        rd_ch(6, v);
        chk("R2 neighbour ch6", v, 0);
    endtask

    task automatic t_mask();
        int v;
        grp_mask[2*16 + 7] = 1'b0;
        conv(7, 2, 'h3FF, 3'b000);
        rd_ch(7, v);
        chk("R3 masked ch not written", v, 0);
        chk("R3 masked flag", int'(grp_flag[2]), 0);
        conv(8, 3, 'h123, 3'b000);
        rd_ch(8, v);
        chk("R3 group code 3 ignored", v, 0);
        chk("R3 flags after bad group", int'(grp_flag), 3'b011);
        grp_mask = '1;
    endtask

    task automatic t_flagclr();
        pulse_clr(3'b011, 3'b000);
        chk("R8 flag cleared", int'(grp_flag), 0);
        @(negedge clk);
        flag_clr = 3'b001;
        conv(1, 0, 'h011, 3'b000);
        flag_clr = '0;
        chk("R8 set beats clear", int'(grp_flag), 3'b001);
        pulse_clr(3'b001, 3'b000);
        chk("R8 cleared again", int'(grp_flag), 0);
    endtask

    task automatic t_buffered();
        int v;
        mode_buf = 1'b1;
        conv(9, 1, 'h0A1, 3'b000);
        conv(3, 1, 'h0A2, 3'b000);
        conv(12, 1, 'h0A3, 3'b000);
        rd_ch(9, v);
        chk("R4 chreg untouched", v, 0);
        chk("R4 head first arrival", head(1), 'h0A1);
        chk("R7 req g1 high", int'(grp_req), 3'b010);
        pop(1);
        chk("R4 second arrival", head(1), 'h0A2);
        pop(1);
        chk("R4 third arrival", head(1), 'h0A3);
        pop(1);
        chk("R5 empty reads zero", head(1), 0);
        chk("R5 empty flag", int'(grp_empty[1]), 1);
        chk("R7 req low when empty", int'(grp_req), 0);
        pop(1);
        chk("R5 pop on empty", int'(grp_empty), 7);
    endtask

    task automatic t_isolation();
        conv(0, 0, 'h100, 3'b000);
        conv(0, 2, 'h200, 3'b000);
        conv(1, 0, 'h101, 3'b000);
        chk("R9 g0 head", head(0), 'h100);
        chk("R9 g2 head", head(2), 'h200);
        chk("R9 g1 empty", int'(grp_empty[1]), 1);
        chk("R9 req", int'(grp_req), 3'b101);
        pop(2);
        chk("R9 g0 head kept", head(0), 'h100);
        pop(0);
        chk("R9 g0 next", head(0), 'h101);
        pop(0);
        chk("R9 all empty", int'(grp_empty), 7);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 16; i++) conv(i, 2, 'h40 + i, 3'b000);
        chk("R6 full at 16", int'(grp_full), 3'b100);
        chk("R6 no overrun yet", int'(grp_ovr), 0);
        conv(4, 2, 'h3FE, 3'b000);
        chk("R6 overrun set", int'(grp_ovr), 3'b100);
        chk("R6 head kept", head(2), 'h40);
        conv(4, 2, 'h3FD, 3'b100);
        chk("R6 push+pop on full drops", int'(grp_full), 0);
        for (int i = 1; i < 16; i++) begin
            chk("R6 stored order", head(2), 'h40 + i);
            pop(2);
        end
        chk("R6 drained", int'(grp_empty[2]), 1);
        chk("R6 overrun sticky", int'(grp_ovr), 3'b100);
        pulse_clr(3'b000, 3'b100);
        chk("R6 overrun cleared", int'(grp_ovr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compat();
        t_mask();
        t_flagclr();
        t_buffered();
        t_isolation();
        t_overrun();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule